// File: doc/BRIEF.md
# Grouped GPIO Bank with Separate Direction Space

This block controls sixty-four general-purpose pins, organised as eight byte-wide groups. Pin `k` sits in group `k/8` at bit `k%8` of every per-group register. Two independent register spaces reach it. The configuration space holds the per-group output-enable bytes and the function-select ("simple I/O") bytes. A configuration-port block drives this space with a byte-wide write strobe, and read data comes back combinationally. A small I/O-space window carries the pin data. Its 16-bit base address is supplied from configuration, and it spans one byte per group.

Each pin presents a tri-state pad interface: an output value, an output enable and a pad input. The output latches can be written at any time, but a pad is driven only while its enable bit is 1. Pad inputs cross a two-flop synchronizer before they can be read. Only the lower five groups have a function-select byte; the upper three keep a fixed function. Unused addresses in either space read as all ones and discard writes.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted and immediately after it, every output-enable bit, every function-select bit and every output latch is 0, so `pad_oe`, `pad_out` and `simple_en` are all zero and every pin is an input.
- R2: A configuration write to address 0xC8+g (g = 0..7) loads group g's output-enable byte, which drives `pad_oe[8g+7:8g]` from the next clock edge on and reads back at the same address. A 1 bit makes the pin an output, and bit b controls pin 8g+b.
- R3: A configuration write to address 0xC0+g for g = 0..4 loads group g's function-select byte onto `simple_en[8g+7:8g]` and reads back at the same address. Addresses 0xC5 to 0xC7 hold no register: they read 0xFF and writes to them change no output.
- R4: An I/O write to address base+g (g = 0..7) loads all eight output latches of group g onto `pad_out[8g+7:8g]` from the next clock edge, whatever the output-enable bits are. The pads of a group are driven only where `pad_oe` is 1.
- R5: An I/O read of address base+g returns `pad_in[8g+7:8g]` as sampled through two flops. A pad change made between clock edges is invisible after the first edge and visible after the second.
- R6: I/O addresses outside base..base+7 read 0xFF, and writes to them change no latch.
- R7: Configuration addresses other than 0xC0 to 0xC4 and 0xC8 to 0xCF read 0xFF, and writes to them change no register.
- R8: A new `io_base` value moves the data window at once, and the old addresses then fall outside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_base | input | 16 | Base address of the data window |
| io_wr | input | 1 | Data window write strobe |
| io_addr | input | 16 | Data window address |
| io_wdata | input | 8 | Data window write data |
| io_rdata | output | 8 | Data window read data (combinational) |
| pad_in | input | 64 | Pad input levels |
| pad_out | output | 64 | Pad output values |
| pad_oe | output | 64 | Pad output enables |
| simple_en | output | 40 | Function-select bits of groups 0 to 4 |

## Verification
A write in either space is taken at one rising edge and shows up on the register outputs straight after that edge. Read data depends only on the address and the registers, with no further delay. A pad input change needs two edges before it appears on `io_rdata`. The bench drives every input at the falling edge and samples one time unit later. It checks the synchronizer after exactly one edge, when the old value must still be visible, and again after two edges, when the new value must be visible. Write results are checked one edge after the write strobe.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned GRP_W_DEF    = 8;
    localparam int unsigned N_GRP_DEF    = 8;
    localparam int unsigned SIO_GRP_DEF  = 5;
    localparam logic [7:0]  OE_BASE_DEF  = 8'hC8;
    localparam logic [7:0]  SIO_BASE_DEF = 8'hC0;
    localparam logic [7:0]  UNMAPPED     = 8'hFF;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned N_GRP    = N_GRP_DEF,
    parameter int unsigned GRP_W    = GRP_W_DEF,
    parameter int unsigned SIO_GRP  = SIO_GRP_DEF,
    parameter int unsigned CFG_AW   = 8,
    parameter logic [7:0]  OE_BASE  = OE_BASE_DEF,
    parameter logic [7:0]  SIO_BASE = SIO_BASE_DEF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [CFG_AW-1:0]               addr,
    input  logic [GRP_W-1:0]                wdata,
    output logic [GRP_W-1:0]                rdata,
    output logic [N_GRP-1:0][GRP_W-1:0]     oe,
    output logic [SIO_GRP-1:0][GRP_W-1:0]   sio
);
    typedef struct packed {
        logic [N_GRP-1:0][GRP_W-1:0]   oe;
        logic [SIO_GRP-1:0][GRP_W-1:0] sio;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = GRP_W'(UNMAPPED);
        for (int g = 0; g < int'(N_GRP); g++) begin
            if (addr == CFG_AW'(int'(OE_BASE) + g)) begin
                rdata = st_q.oe[g];
                if (wr) st_d.oe[g] = wdata;
            end
        end
        for (int g = 0; g < int'(SIO_GRP); g++) begin
            if (addr == CFG_AW'(int'(SIO_BASE) + g)) begin
                rdata = st_q.sio[g];
                if (wr) st_d.sio[g] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe  = st_q.oe;
    assign sio = st_q.sio;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W      = 64,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/gpio_data_regs.sv
module gpio_data_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned N_GRP = N_GRP_DEF,
    parameter int unsigned GRP_W = GRP_W_DEF,
    parameter int unsigned IO_AW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IO_AW-1:0]            base,
    input  logic                        wr,
    input  logic [IO_AW-1:0]            addr,
    input  logic [GRP_W-1:0]            wdata,
    input  logic [N_GRP-1:0][GRP_W-1:0] level,
    output logic [GRP_W-1:0]            rdata,
    output logic [N_GRP-1:0][GRP_W-1:0] latch
);
    typedef struct packed {
        logic [N_GRP-1:0][GRP_W-1:0] lat;
    } data_state_t;

    data_state_t      st_d, st_q;
    logic [IO_AW-1:0] offset;

    assign offset = addr - base;

    always_comb begin
        st_d  = st_q;
        rdata = GRP_W'(UNMAPPED);
        for (int g = 0; g < int'(N_GRP); g++) begin
            if (offset == IO_AW'(g)) begin
                rdata = level[g];
                if (wr) st_d.lat[g] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.lat;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned N_GRP    = N_GRP_DEF,
    parameter int unsigned GRP_W    = GRP_W_DEF,
    parameter int unsigned SIO_GRP  = SIO_GRP_DEF,
    parameter int unsigned CFG_AW   = 8,
    parameter int unsigned IO_AW    = 16,
    parameter int unsigned SYNC_N   = 2,
    parameter logic [7:0]  OE_BASE  = OE_BASE_DEF,
    parameter logic [7:0]  SIO_BASE = SIO_BASE_DEF,
    localparam int unsigned LINES   = N_GRP * GRP_W,
    localparam int unsigned SIO_W   = SIO_GRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [GRP_W-1:0]  cfg_wdata,
    output logic [GRP_W-1:0]  cfg_rdata,
    input  logic [IO_AW-1:0]  io_base,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [GRP_W-1:0]  io_wdata,
    output logic [GRP_W-1:0]  io_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe,
    output logic [SIO_W-1:0]  simple_en
);
    logic [N_GRP-1:0][GRP_W-1:0]   oe_bits;
    logic [SIO_GRP-1:0][GRP_W-1:0] sio_bits;
    logic [N_GRP-1:0][GRP_W-1:0]   lat_bits;
    logic [LINES-1:0]              sync_lvl;

    gpio_cfg_regs #(
        .N_GRP(N_GRP), .GRP_W(GRP_W), .SIO_GRP(SIO_GRP), .CFG_AW(CFG_AW),
        .OE_BASE(OE_BASE), .SIO_BASE(SIO_BASE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .oe(oe_bits), .sio(sio_bits)
    );

    gpio_in_sync #(.W(LINES), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_lvl)
    );

    gpio_data_regs #(.N_GRP(N_GRP), .GRP_W(GRP_W), .IO_AW(IO_AW)) u_data (
        .clk(clk), .rst_n(rst_n), .base(io_base), .wr(io_wr), .addr(io_addr),
        .wdata(io_wdata), .level(sync_lvl), .rdata(io_rdata), .latch(lat_bits)
    );

    assign pad_oe    = oe_bits;
    assign pad_out   = lat_bits;
    assign simple_en = sio_bits;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int unsigned N_GRP    = 8,
    parameter int unsigned GRP_W    = 8,
    parameter int unsigned SIO_GRP  = 5,
    parameter int unsigned CFG_AW   = 8,
    parameter int unsigned IO_AW    = 16,
    parameter logic [7:0]  OE_BASE  = 8'hC8,
    parameter logic [7:0]  SIO_BASE = 8'hC0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_wr,
    input logic [CFG_AW-1:0]          cfg_addr,
    input logic [GRP_W-1:0]           cfg_wdata,
    input logic [GRP_W-1:0]           cfg_rdata,
    input logic [IO_AW-1:0]           io_base,
    input logic                       io_wr,
    input logic [IO_AW-1:0]           io_addr,
    input logic [GRP_W-1:0]           io_wdata,
    input logic [GRP_W-1:0]           io_rdata,
    input logic [N_GRP*GRP_W-1:0]     pad_in,
    input logic [N_GRP*GRP_W-1:0]     pad_out,
    input logic [N_GRP*GRP_W-1:0]     pad_oe,
    input logic [SIO_GRP*GRP_W-1:0]   simple_en
);
    logic [1:0]       run_cnt;
    logic [IO_AW-1:0] win_off;
    logic             cfg_mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    assign win_off    = io_addr - io_base;
    assign cfg_mapped = (int'(cfg_addr) >= int'(OE_BASE) && int'(cfg_addr) < int'(OE_BASE) + int'(N_GRP))
                     || (int'(cfg_addr) >= int'(SIO_BASE) && int'(cfg_addr) < int'(SIO_BASE) + int'(SIO_GRP));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && simple_en == '0)); // R1

    AST_CFG_HOLE_FF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mapped |-> cfg_rdata == '1); // R7

    AST_IO_OUTSIDE_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (win_off >= IO_AW'(N_GRP)) |-> io_rdata == '1); // R6

    for (genvar g = 0; g < int'(N_GRP); g++) begin : g_grp
        AST_OE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && cfg_addr == CFG_AW'(int'(OE_BASE) + g))
            |=> pad_oe[g*GRP_W +: GRP_W] == $past(cfg_wdata)); // R2

        AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_wr && cfg_addr == CFG_AW'(int'(OE_BASE) + g))
            |=> $stable(pad_oe[g*GRP_W +: GRP_W])); // R7

        AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (io_wr && win_off == IO_AW'(g))
            |=> pad_out[g*GRP_W +: GRP_W] == $past(io_wdata)); // R4

        AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(io_wr && win_off == IO_AW'(g))
            |=> $stable(pad_out[g*GRP_W +: GRP_W])); // R6

        AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            (run_cnt >= 2'd2 && win_off == IO_AW'(g))
            |-> io_rdata == $past(pad_in[g*GRP_W +: GRP_W], 2)); // R5
    end

    for (genvar g = 0; g < int'(SIO_GRP); g++) begin : g_sio
        AST_SIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && cfg_addr == CFG_AW'(int'(SIO_BASE) + g))
            |=> simple_en[g*GRP_W +: GRP_W] == $past(cfg_wdata)); // R3

        AST_SIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_wr && cfg_addr == CFG_AW'(int'(SIO_BASE) + g))
            |=> $stable(simple_en[g*GRP_W +: GRP_W])); // R3
    end
endmodule

bind gpio_bank gpio_bank_chk #(
    .N_GRP(N_GRP), .GRP_W(GRP_W), .SIO_GRP(SIO_GRP), .CFG_AW(CFG_AW),
    .IO_AW(IO_AW), .OE_BASE(OE_BASE), .SIO_BASE(SIO_BASE)
) u_chk (.*);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_base = 16'h0A00;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [63:0] pad_in = 64'h0;
    logic [63:0] pad_out;
    logic [63:0] pad_oe;
    logic [39:0] simple_en;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_base(io_base),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .simple_en(simple_en)
    );

    // vector: {kind[1:0], req[3:0], addr[15:0], data[7:0], expect[7:0]}
    // kind 0 cfg write, 1 cfg read, 2 io write, 3 io read
    localparam int NV = 18;
    localparam logic [37:0] VEC [NV] = '{
        {2'd1, 4'd1, 16'h00C8, 8'h00, 8'h00},
        {2'd0, 4'd2, 16'h00C8, 8'hA5, 8'h00},
        {2'd1, 4'd2, 16'h00C8, 8'h00, 8'hA5},
        {2'd0, 4'd2, 16'h00CF, 8'h3C, 8'h00},
        {2'd1, 4'd2, 16'h00CF, 8'h00, 8'h3C},
        {2'd0, 4'd3, 16'h00C0, 8'h5A, 8'h00},
        {2'd1, 4'd3, 16'h00C0, 8'h00, 8'h5A},
        {2'd0, 4'd3, 16'h00C4, 8'h81, 8'h00},
        {2'd1, 4'd3, 16'h00C4, 8'h00, 8'h81},
        {2'd0, 4'd3, 16'h00C5, 8'h12, 8'h00},
        {2'd1, 4'd3, 16'h00C5, 8'h00, 8'hFF},
        {2'd0, 4'd7, 16'h0010, 8'h66, 8'h00},
        {2'd1, 4'd7, 16'h0010, 8'h00, 8'hFF},
        {2'd3, 4'd5, 16'h0A00, 8'h00, 8'hEF},
        {2'd3, 4'd5, 16'h0A02, 8'h00, 8'hAB},
        {2'd3, 4'd5, 16'h0A07, 8'h00, 8'h01},
        {2'd3, 4'd6, 16'h0A08, 8'h00, 8'hFF},
        {2'd3, 4'd6, 16'h09FF, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 oe", pad_oe, 64'h0);
        check("R1 out", pad_out, 64'h0);
        check("R1 sio", {24'h0, simple_en}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after release", pad_oe, 64'h0);

        pad_in = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[35:32], i);
            case (v[37:36])
                2'd0: cfg_write(v[23:16], v[15:8]);
                2'd2: io_write(v[31:16], v[15:8]);
                2'd1: begin
                    @(negedge clk); cfg_addr = v[23:16]; #1;
                    check(tag, {56'h0, cfg_rdata}, {56'h0, v[7:0]});
                end
                default: begin
                    @(negedge clk); io_addr = v[31:16]; #1;
                    check(tag, {56'h0, io_rdata}, {56'h0, v[7:0]});
                end
            endcase
        end

        // R2 / R3 / R7: output side after the table
        check("R2 pad_oe", pad_oe, 64'h3C00_0000_0000_00A5);
        check("R3 simple_en", {24'h0, simple_en}, {24'h0, 40'h81_0000_005A});

        // R2 mapping: line 42 is group 5 bit 2
        cfg_write(8'hCD, 8'h04);
        #1 check("R2 line42", {63'h0, pad_oe[42]}, 64'h1);
        check("R2 group5 only", pad_oe, 64'h3C00_0400_0000_00A5);

        // R4: latch written even with OE clear on group 3
        io_write(16'h0A03, 8'hC3);
        #1 check("R4 pad_out", pad_out, 64'h0000_0000_C300_0000);

        // R6: write beyond window ignored
        io_write(16'h0A08, 8'h55);
        io_write(16'h09FF, 8'h55);
        #1 check("R6 pad_out kept", pad_out, 64'h0000_0000_C300_0000);

        // R5: two-flop delay on group 1
        @(negedge clk);
        io_addr = 16'h0A01;
        pad_in[15:8] = 8'h5E;
        #1 check("R5 edge0", {56'h0, io_rdata}, 64'hCD);
        @(negedge clk); #1 check("R5 edge1 old", {56'h0, io_rdata}, 64'hCD);
        @(negedge clk); #1 check("R5 edge2 new", {56'h0, io_rdata}, 64'h5E);

        // R8: window moves with io_base
        @(negedge clk);
        io_base = 16'h0300;
        io_addr = 16'h0A00; #1
        check("R8 old window", {56'h0, io_rdata}, 64'hFF);
        io_addr = 16'h0302; #1
        check("R8 new window read", {56'h0, io_rdata}, 64'hAB);
        io_write(16'h0307, 8'h77);
        #1 check("R8 new window write", pad_out, 64'h7700_0000_C300_0000);

        // R1: reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1 re-reset", pad_oe | pad_out, 64'h0);
        check("R1 re-reset sio", {24'h0, simple_en}, 64'h0);

        summary();
    end
endmodule